// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers eight event sources of an audio interface into one byte of sticky status flags. It adds a byte of interrupt enables beside them and drives a single active-high interrupt line toward a host processor. Any event sets its flag, and the flag stays set until the host reads the status byte. That read returns the flags as they stand and then clears them. Two of the flags are summaries: each one is the OR of a wider vector of error sources kept elsewhere, and the host follows up by reading that other error register.

The host reaches the block through a plain register port with a 7-bit address, a read strobe and a write strobe. The status byte sits at address 0x1C and the enable byte at 0x1D. One flag, the receive channel-status A/B mismatch, is sticky like the rest but can never raise the interrupt, because its enable slot is fixed at zero. The flag for receive channel-status events changes its trigger with a configuration input. The flag for transmit channel-status collisions sets only when a buffer write lands during a copy.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, the enable byte reads 0x00 and `irq` is low.
- R2: Flag positions, from bit 7 down to bit 0: converter error summary, transmit channel-status write collision, transmit user buffer empty, transmit channel-status block sent, receive channel-status A/B mismatch, receive user buffer new block, receive channel-status event, receiver error summary. An event in one cycle sets its flag from the next clock edge on, and the flag stays set until the status byte is read.
- R3: A read of the status byte (address 0x1C) returns the current flags in that same cycle and clears them at the next edge. An event that arrives in the cycle of the clearing read leaves its flag set.
- R4: A write to address 0x1D loads the enable byte with bit 3 forced to 0. A read of 0x1D returns the enable byte, and bit 3 always reads 0. An enable bit of 1 lets the flag at the same position raise the interrupt.
- R5: `irq` is registered. It equals the OR of (flags AND enables) over bits 7..4 and 2..0, and it follows those values one clock edge later.
- R6: The mismatch flag (bit 3) never raises `irq`, even when a write of 0xFF is made to the enable byte.
- R7: Bit 6 sets only when `tx_cs_buf_wr` and `tx_cs_copy_busy` are high in the same cycle. Either one alone sets nothing.
- R8: With `rx_cs_on_change` at 0, every `rx_cs_block` pulse sets bit 1. With it at 1, a block sets bit 1 only if `rx_cs_changed` is high in the same cycle.
- R9: Bit 7 sets when any bit of `conv_err_src` is high, and bit 0 sets when any bit of `rx_err_src` is high.
- R10: Writes to address 0x1C leave the flags unchanged.
- R11: Reads of the enable byte, and reads at any other address, do not clear the flags. A read at an unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | 7 | Register address |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of `reg_rd`, 0 otherwise |
| conv_err_src | input | CONV_ERR_W | Sample rate converter error sources |
| rx_err_src | input | RX_ERR_W | Receiver error sources |
| tx_cs_buf_wr | input | 1 | Host write into the transmit channel-status buffer |
| tx_cs_copy_busy | input | 1 | Transmit channel-status copy in progress |
| tx_ub_empty | input | 1 | Transmit user buffer empty event |
| tx_cs_sent | input | 1 | Transmit channel-status block sent event |
| rx_cs_mismatch | input | 1 | Receive channel-status A/B mismatch event |
| rx_ub_new | input | 1 | Receive user buffer new block event |
| rx_cs_block | input | 1 | New receive channel-status block |
| rx_cs_changed | input | 1 | Receive channel-status content differs from the previous block |
| rx_cs_on_change | input | 1 | Configuration: 0 flags every block, 1 flags only changed blocks |
| irq | output | 1 | Interrupt to host, active high |

## Verification
Read data is combinational, so the bench samples `reg_rdata` in the same cycle as the read strobe. A flag set by an event shows up in a read one edge after the event, and an enable write shows up in a read one edge after the write. `irq` needs one more edge after the flag or enable changes. The bench keeps a reference model that it updates at each rising edge. It checks the outputs one nanosecond after the falling edge, against the model state as it stood before the next rising edge, so every comparison lines up with these delays. The directed cases place the clearing read and a new event in the same cycle, and they drive each source condition on its own to show that the partial conditions set nothing.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

  localparam int unsigned FLAG_W = 8;

  // flag positions (the host decodes these)
  localparam int unsigned FB_CONV_ERR  = 7;
  localparam int unsigned FB_TX_COLL   = 6;
  localparam int unsigned FB_TX_UB     = 5;
  localparam int unsigned FB_TX_CS     = 4;
  localparam int unsigned FB_RX_MISM   = 3;
  localparam int unsigned FB_RX_UB     = 2;
  localparam int unsigned FB_RX_CS     = 1;
  localparam int unsigned FB_RX_ERR    = 0;

  // flags allowed to reach the interrupt line
  localparam logic [FLAG_W-1:0] IRQ_CAPABLE = 8'hF7;

  typedef logic [FLAG_W-1:0] flag_t;

endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond
  import irq_status_pkg::*;
#(
  parameter int unsigned CONV_ERR_W = 4,
  parameter int unsigned RX_ERR_W   = 6
) (
  input  logic [CONV_ERR_W-1:0] conv_err_src,
  input  logic [RX_ERR_W-1:0]   rx_err_src,
  input  logic                  tx_cs_buf_wr,
  input  logic                  tx_cs_copy_busy,
  input  logic                  tx_ub_empty,
  input  logic                  tx_cs_sent,
  input  logic                  rx_cs_mismatch,
  input  logic                  rx_ub_new,
  input  logic                  rx_cs_block,
  input  logic                  rx_cs_changed,
  input  logic                  rx_cs_on_change,
  output flag_t                 set_vec
);

  logic cs_evt;

  always_comb begin
    cs_evt = rx_cs_on_change ? (rx_cs_block & rx_cs_changed) : rx_cs_block;
  end

  always_comb begin
    set_vec              = '0;
    set_vec[FB_CONV_ERR] = |conv_err_src;
    set_vec[FB_TX_COLL]  = tx_cs_buf_wr & tx_cs_copy_busy;
    set_vec[FB_TX_UB]    = tx_ub_empty;
    set_vec[FB_TX_CS]    = tx_cs_sent;
    set_vec[FB_RX_MISM]  = rx_cs_mismatch;
    set_vec[FB_RX_UB]    = rx_ub_new;
    set_vec[FB_RX_CS]    = cs_evt;
    set_vec[FB_RX_ERR]   = |rx_err_src;
  end

endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] set_vec,
  output logic [W-1:0] flags
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic nxt;
    logic q;
    logic en;

    always_comb begin
      // a new event takes priority over the clear
      en  = clr | set_vec[i];
      nxt = set_vec[i] | (q & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= 1'b0;
      end else if (en) begin
        q <= nxt;
      end
    end

    assign flags[i] = q;
  end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned W        = 8,
  parameter logic [W-1:0] WR_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);

  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;

  always_comb begin
    mask_d = wdata & WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_en) begin
      mask_q <= mask_d;
    end
  end

  assign mask = mask_q;

endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
  parameter int unsigned W        = 8,
  parameter logic [W-1:0] EN_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flags,
  input  logic [W-1:0] mask,
  output logic         irq
);

  logic irq_d;
  logic irq_q;

  always_comb begin
    irq_d = |(flags & mask & EN_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 7,
  parameter logic [ADDR_W-1:0]  STAT_ADDR  = 7'h1C,
  parameter logic [ADDR_W-1:0]  MASK_ADDR  = 7'h1D,
  parameter int unsigned        CONV_ERR_W = 4,
  parameter int unsigned        RX_ERR_W   = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_rd,
  input  logic                  reg_wr,
  input  logic [FLAG_W-1:0]     reg_wdata,
  output logic [FLAG_W-1:0]     reg_rdata,
  input  logic [CONV_ERR_W-1:0] conv_err_src,
  input  logic [RX_ERR_W-1:0]   rx_err_src,
  input  logic                  tx_cs_buf_wr,
  input  logic                  tx_cs_copy_busy,
  input  logic                  tx_ub_empty,
  input  logic                  tx_cs_sent,
  input  logic                  rx_cs_mismatch,
  input  logic                  rx_ub_new,
  input  logic                  rx_cs_block,
  input  logic                  rx_cs_changed,
  input  logic                  rx_cs_on_change,
  output logic                  irq
);

  localparam int unsigned RST_STAGES = 2;

  // reset: asynchronous assert, synchronous release
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
    end
  end

  assign rst_core_n = rst_pipe[RST_STAGES-1];

  // address decode
  logic  hit_stat;
  logic  hit_mask;
  logic  stat_clr;
  logic  mask_we;
  flag_t set_vec;
  flag_t status_q;
  flag_t mask_q;

  always_comb begin
    hit_stat = (reg_addr == STAT_ADDR);
    hit_mask = (reg_addr == MASK_ADDR);
    stat_clr = reg_rd & hit_stat;
    mask_we  = reg_wr & hit_mask;
  end

  irq_src_cond #(
    .CONV_ERR_W (CONV_ERR_W),
    .RX_ERR_W   (RX_ERR_W)
  ) u_src (
    .conv_err_src    (conv_err_src),
    .rx_err_src      (rx_err_src),
    .tx_cs_buf_wr    (tx_cs_buf_wr),
    .tx_cs_copy_busy (tx_cs_copy_busy),
    .tx_ub_empty     (tx_ub_empty),
    .tx_cs_sent      (tx_cs_sent),
    .rx_cs_mismatch  (rx_cs_mismatch),
    .rx_ub_new       (rx_ub_new),
    .rx_cs_block     (rx_cs_block),
    .rx_cs_changed   (rx_cs_changed),
    .rx_cs_on_change (rx_cs_on_change),
    .set_vec         (set_vec)
  );

  irq_sticky_bank #(
    .W (FLAG_W)
  ) u_flags (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .clr     (stat_clr),
    .set_vec (set_vec),
    .flags   (status_q)
  );

  irq_mask_reg #(
    .W       (FLAG_W),
    .WR_MASK (IRQ_CAPABLE)
  ) u_mask (
    .clk   (clk),
    .rst_n (rst_core_n),
    .wr_en (mask_we),
    .wdata (reg_wdata),
    .mask  (mask_q)
  );

  irq_out_gen #(
    .W       (FLAG_W),
    .EN_MASK (IRQ_CAPABLE)
  ) u_irq (
    .clk   (clk),
    .rst_n (rst_core_n),
    .flags (status_q),
    .mask  (mask_q),
    .irq   (irq)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (hit_stat) begin
        reg_rdata = status_q;
      end else if (hit_mask) begin
        reg_rdata = mask_q;
      end
    end
  end

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int unsigned       ADDR_W    = 7,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 7'h1C,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 7'h1D
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        set_vec,
  input logic [7:0]        status_q,
  input logic [7:0]        mask_q,
  input logic              irq
);

  assert_irq_low_at_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq && status_q == 8'h00 && mask_q == 8'h00));

  assert_event_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 8'h00) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_addr == STAT_ADDR) |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == STAT_ADDR && set_vec == 8'h00) |=> (status_q == 8'h00));

  assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == MASK_ADDR) |=> (mask_q == ($past(reg_wdata) & 8'hF7)));

  assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & mask_q & 8'hF7) != 8'h00 |=> irq);

  assert_mismatch_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == 8'h08) |=> !irq);

  assert_status_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == STAT_ADDR && !reg_rd && set_vec == 8'h00) |=> $stable(status_q));

endmodule

bind irq_status_ctrl irq_status_chk #(
  .ADDR_W    (ADDR_W),
  .STAT_ADDR (STAT_ADDR),
  .MASK_ADDR (MASK_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .reg_addr  (reg_addr),
  .reg_rd    (reg_rd),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .set_vec   (set_vec),
  .status_q  (status_q),
  .mask_q    (mask_q),
  .irq       (irq)
);

// File: tb/irq_status_ctrl_test.sv
`timescale 1ns/1ps
module irq_status_ctrl_test;

  localparam int CW = 4;
  localparam int RW = 6;
  localparam logic [6:0] A_ST = 7'h1C;
  localparam logic [6:0] A_MK = 7'h1D;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [6:0]    reg_addr;
  logic          reg_rd, reg_wr;
  logic [7:0]    reg_wdata, reg_rdata;
  logic [CW-1:0] conv_err_src;
  logic [RW-1:0] rx_err_src;
  logic tx_cs_buf_wr, tx_cs_copy_busy, tx_ub_empty, tx_cs_sent;
  logic rx_cs_mismatch, rx_ub_new, rx_cs_block, rx_cs_changed, rx_cs_on_change;
  logic irq;

  int   n_tests = 0;
  int   n_fail  = 0;
  logic [7:0] st_e, mk_e, rd_val;
  logic irq_e;

  always #10 clk = ~clk;

  irq_status_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_err_src(conv_err_src),
    .rx_err_src(rx_err_src), .tx_cs_buf_wr(tx_cs_buf_wr), .tx_cs_copy_busy(tx_cs_copy_busy),
    .tx_ub_empty(tx_ub_empty), .tx_cs_sent(tx_cs_sent), .rx_cs_mismatch(rx_cs_mismatch),
    .rx_ub_new(rx_ub_new), .rx_cs_block(rx_cs_block), .rx_cs_changed(rx_cs_changed),
    .rx_cs_on_change(rx_cs_on_change), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_addr = '0; reg_rd = 0; reg_wr = 0; reg_wdata = '0;
    conv_err_src = '0; rx_err_src = '0;
    tx_cs_buf_wr = 0; tx_cs_copy_busy = 0; tx_ub_empty = 0; tx_cs_sent = 0;
    rx_cs_mismatch = 0; rx_ub_new = 0; rx_cs_block = 0; rx_cs_changed = 0;
  endtask

  function automatic logic [7:0] set_of();
    logic [7:0] s;
    s[7] = |conv_err_src;
    s[6] = tx_cs_buf_wr & tx_cs_copy_busy;
    s[5] = tx_ub_empty;
    s[4] = tx_cs_sent;
    s[3] = rx_cs_mismatch;
    s[2] = rx_ub_new;
    s[1] = rx_cs_on_change ? (rx_cs_block & rx_cs_changed) : rx_cs_block;
    s[0] = |rx_err_src;
    return s;
  endfunction

  // one cycle: inputs already applied at a falling edge
  task automatic cyc();
    logic [7:0] s;
    #1;
    rd_val = reg_rdata;
    if (reg_rd) begin
      if (reg_addr == A_ST) check("R2 status read", reg_rdata, st_e);
      else if (reg_addr == A_MK) check("R4 mask read", reg_rdata, mk_e);
      else check("R11 unmapped read", reg_rdata, 8'h00);
    end
    check("R5 irq", {7'd0, irq}, {7'd0, irq_e});
    @(posedge clk);
    s = set_of();
    irq_e = |(st_e & mk_e & 8'hF7);
    st_e = ((reg_rd && reg_addr == A_ST) ? 8'h00 : st_e) | s;
    if (reg_wr && reg_addr == A_MK) mk_e = reg_wdata & 8'hF7;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [6:0] a);
    reg_addr = a; reg_rd = 1; cyc();
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    reg_addr = a; reg_wr = 1; reg_wdata = d; cyc();
  endtask

  initial begin
    void'($urandom(32'd2024));
    idle();
    rx_cs_on_change = 0;
    rst_n = 0;
    st_e = 0; mk_e = 0; irq_e = 0; rd_val = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(A_ST); check("R1 status after reset", rd_val, 8'h00);
    rd(A_MK); check("R1 mask after reset", rd_val, 8'h00);
    check("R1 irq after reset", {7'd0, irq}, 8'h00);

    // R4 reserved enable bit
    wr(A_MK, 8'hFF);
    rd(A_MK); check("R4 reserved bit reads 0", rd_val, 8'hF7);

    // R6 mismatch flag sticky but silent
    rx_cs_mismatch = 1; cyc();
    cyc(); cyc();
    check("R6 no irq from mismatch", {7'd0, irq}, 8'h00);
    rd(A_ST); check("R2 mismatch at bit 3", rd_val, 8'h08);
    rd(A_ST); check("R3 cleared after read", rd_val, 8'h00);

    // R7 collision needs both conditions
    tx_cs_buf_wr = 1; cyc();
    tx_cs_copy_busy = 1; cyc();
    rd(A_ST); check("R7 partial condition", rd_val, 8'h00);
    tx_cs_buf_wr = 1; tx_cs_copy_busy = 1; cyc();
    rd(A_ST); check("R7 collision bit 6", rd_val, 8'h40);

    // R8 configuration choice
    rx_cs_on_change = 0; rx_cs_block = 1; cyc();
    rd(A_ST); check("R8 every block", rd_val, 8'h02);
    rx_cs_on_change = 1; rx_cs_block = 1; cyc();
    rd(A_ST); check("R8 unchanged block ignored", rd_val, 8'h00);
    rx_cs_changed = 1; cyc();
    rd(A_ST); check("R8 changed without block", rd_val, 8'h00);
    rx_cs_block = 1; rx_cs_changed = 1; cyc();
    rd(A_ST); check("R8 changed block", rd_val, 8'h02);
    rx_cs_on_change = 0;

    // R9 summaries
    conv_err_src = 4'b0100; cyc();
    rd(A_ST); check("R9 converter summary", rd_val, 8'h80);
    rx_err_src = 6'b100000; cyc();
    rd(A_ST); check("R9 receiver summary", rd_val, 8'h01);

    // R3 event during clearing read wins; R5 timing
    wr(A_MK, 8'h20);
    rx_ub_new = 1; cyc();
    reg_addr = A_ST; reg_rd = 1; tx_ub_empty = 1; cyc();
    check("R3 read returns old flags", rd_val, 8'h04);
    check("R5 irq not yet", {7'd0, irq}, 8'h00);
    cyc();
    check("R5 irq one edge later", {7'd0, irq}, 8'h01);

    // R10 status writes, R11 other reads keep flags
    wr(A_ST, 8'h00);
    rd(A_MK);
    rd(7'h05); check("R11 unmapped reads 0", rd_val, 8'h00);
    rd(A_ST); check("R10 flags kept", rd_val, 8'h20);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      conv_err_src   = ($urandom_range(0, 15) == 0) ? CW'($urandom) : '0;
      rx_err_src     = ($urandom_range(0, 15) == 0) ? RW'($urandom) : '0;
      tx_cs_buf_wr   = $urandom_range(0, 3) == 0;
      tx_cs_copy_busy= $urandom_range(0, 1) == 0;
      tx_ub_empty    = $urandom_range(0, 11) == 0;
      tx_cs_sent     = $urandom_range(0, 11) == 0;
      rx_cs_mismatch = $urandom_range(0, 11) == 0;
      rx_ub_new      = $urandom_range(0, 11) == 0;
      rx_cs_block    = $urandom_range(0, 5) == 0;
      rx_cs_changed  = $urandom_range(0, 1) == 0;
      if (i % 97 == 0) rx_cs_on_change = ~rx_cs_on_change;
      if (k < 3) begin reg_addr = A_ST; reg_rd = 1; end
      else if (k == 3) begin reg_addr = A_MK; reg_rd = 1; end
      else if (k == 4) begin reg_addr = A_MK; reg_wr = 1; reg_wdata = 8'($urandom); end
      else if (k == 5) begin reg_addr = A_ST; reg_wr = 1; reg_wdata = 8'($urandom); end
      cyc();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule